// File: doc/BRIEF.md
# Programmable Up/Down Timer Counter

A general-purpose timer whose counter advances on ticks from a programmable clock divider. It runs in one of three ways: counting up from zero to a period limit, counting down from the period limit to zero, or swinging between zero and the period limit (centre-aligned). Each turn of the count raises a sticky event flag, which software clears. The current count and counting direction are exposed as ports.

Software reaches the timer through a small synchronous register port with a combinational read. The period limit can be written straight into the live register, or it can be staged in a shadow that takes over only at the next turn. The divider ratio is always staged this way. A software update request forces a restart: it reloads the counter, moves the staged values into the live registers and restarts the divider.

Register map (word addresses): 0 control, 1 status, 2 count (read-only), 3 period, 4 divider. Control bits: bit 0 enable, bit 1 period buffering, bit 2 direction (0 up, 1 down), bits 4:3 mode (00 edge-aligned, any other value centre-aligned), bit 5 update request (write 1 to request, always reads 0). Status bit 0 is the event flag.

Top module: `updn_timer`

## Requirements
- R1: After reset the count is 0, the flag is 0, the direction is up, the counter is disabled, the period register reads 0xFFFF and the divider register reads 0. Control reads 0.
- R2: In edge-aligned mode with direction 0, each tick adds 1 to the count. A tick that finds the count at or above the period sets the count to 0 and raises an event.
- R3: In edge-aligned mode with direction 1, each tick subtracts 1 from the count. A tick that finds the count at 0 loads the period and raises an event.
- R4: In centre-aligned mode, an upward tick from PR-1 (or above) loads PR, turns the direction to down and raises an event. A downward tick from 1 (or 0) loads 0, turns the direction to up and raises an event. With PR=3 the count runs 0,1,2,3,2,1,0,1 with events on arrival at 3 and at 0.
- R5: Control bit 2 and the direction output always show the current direction. Software can write it only while the mode field is 00; in centre-aligned mode, writes to bit 2 are ignored.
- R6: While buffering (control bit 1) is set, a period write goes only to the shadow, and reading address 3 returns it. The live period takes the shadow value at the next event or update request, so the count still wraps at the old period first.
- R7: While buffering is clear, a period write is live from the following clock cycle.
- R8: A tick occurs on every (D+1)-th clock while enabled, where D is the live divider ratio. A divider write is staged and goes live, with the divider phase restarted, only at an event or an update request.
- R9: Every event sets the flag (status bit 0). Writing 0 to status bit 0 clears it, and writing 1 has no effect. When an event and a clear fall in the same cycle, the flag ends up set.
- R10: Writing 1 to control bit 5 reloads the count (0 if the direction held before that write is up, otherwise the staged period). It also moves both shadows into the live registers and restarts the divider phase. It does not set the flag and takes precedence over a tick in the same cycle.
- R11: While control bit 0 is clear, the count and the divider phase hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | BUS_W (16) | Register write data |
| reg_rdata | output | BUS_W (16) | Register read data, combinational from reg_addr |
| count_o | output | CNT_W (16) | Current count |
| dir_o | output | 1 | Current direction, 1 = down |
| flag_o | output | 1 | Sticky event flag |

## Verification
The flag can receive a hardware set from a counter turn and a software clear in the same clock cycle. The bench provokes this with no prescaling and a known period: it counts the cycles up to the turn and then writes 0 to the status register so that the write lands exactly on the clock edge where the count wraps. The flag must read 1 afterwards. A second clear one cycle later must then bring it to 0, which shows that the first clear was overridden rather than lost.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL   = 3'd0,
      RA_STAT   = 3'd1,
      RA_COUNT  = 3'd2,
      RA_PERIOD = 3'd3,
      RA_DIV    = 3'd4
   } reg_addr_e;

   // control register bit positions
   localparam int unsigned CB_EN   = 0;
   localparam int unsigned CB_BUF  = 1;
   localparam int unsigned CB_DIR  = 2;
   localparam int unsigned CB_MODE = 3;   // two bits, 4:3
   localparam int unsigned CB_UPD  = 5;
   localparam int unsigned CTRL_W  = 6;

   typedef struct packed {
      logic       en;
      logic       buf_en;
      logic [1:0] mode;
   } ctrl_t;
endpackage

// File: rtl/updn_timer_regs.sv
module updn_timer_regs
   import updn_timer_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int DIV_W = 16,
   parameter int BUS_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   input  logic              hw_evt,
   input  logic              dir_stat,
   input  logic [CNT_W-1:0]  count,
   output ctrl_t             ctrl,
   output logic              sw_upd,
   output logic              dir_we,
   output logic              dir_wval,
   output logic [CNT_W-1:0]  per_shadow,
   output logic [CNT_W-1:0]  per_act,
   output logic [DIV_W-1:0]  div_shadow,
   output logic              flag
);
   logic wr_ctrl, wr_stat, wr_per, wr_div, update;

   assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
   assign wr_stat  = reg_wr && (reg_addr == RA_STAT);
   assign wr_per   = reg_wr && (reg_addr == RA_PERIOD);
   assign wr_div   = reg_wr && (reg_addr == RA_DIV);
   assign sw_upd   = wr_ctrl && reg_wdata[CB_UPD];
   assign update   = hw_evt || sw_upd;
   assign dir_we   = wr_ctrl && (ctrl.mode == 2'b00);
   assign dir_wval = reg_wdata[CB_DIR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl       <= '0;
         per_shadow <= '1;
         per_act    <= '1;
         div_shadow <= '0;
         flag       <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl.en     <= reg_wdata[CB_EN];
            ctrl.buf_en <= reg_wdata[CB_BUF];
            ctrl.mode   <= reg_wdata[CB_MODE +: 2];
         end
         if (wr_per)
            per_shadow <= reg_wdata[CNT_W-1:0];
         if (wr_per && !ctrl.buf_en)
            per_act <= reg_wdata[CNT_W-1:0];
         else if (update)
            per_act <= per_shadow;
         if (wr_div)
            div_shadow <= reg_wdata[DIV_W-1:0];
         // a hardware event outranks a software clear in the same cycle
         if (hw_evt)
            flag <= 1'b1;
         else if (wr_stat && !reg_wdata[0])
            flag <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_CTRL: begin
            reg_rdata[CB_EN]         = ctrl.en;
            reg_rdata[CB_BUF]        = ctrl.buf_en;
            reg_rdata[CB_DIR]        = dir_stat;
            reg_rdata[CB_MODE +: 2]  = ctrl.mode;
         end
         RA_STAT:   reg_rdata[0]       = flag;
         RA_COUNT:  reg_rdata[CNT_W-1:0] = count;
         RA_PERIOD: reg_rdata[CNT_W-1:0] = per_shadow;
         RA_DIV:    reg_rdata[DIV_W-1:0] = div_shadow;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/updn_timer_presc.sv
module updn_timer_presc #(
   parameter int DIV_W    = 16,
   parameter bit PRESC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             update,
   input  logic [DIV_W-1:0] div_shadow,
   output logic             tick
);
   generate
      if (PRESC_EN) begin : g_div
         logic [DIV_W-1:0] div_act, div_cnt;

         assign tick = en && (div_cnt == div_act);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_act <= '0;
               div_cnt <= '0;
            end else if (update) begin
               div_act <= div_shadow;
               div_cnt <= '0;
            end else if (en) begin
               div_cnt <= tick ? '0 : div_cnt + 1'b1;
            end
         end
      end else begin : g_nodiv
         logic unused_presc;
         assign unused_presc = ^{div_shadow, update, clk, rst_n};
         assign tick         = en;
      end
   endgenerate
endmodule

// File: rtl/updn_timer_core.sv
module updn_timer_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             sw_upd,
   input  logic             center,
   input  logic             dir_we,
   input  logic             dir_wval,
   input  logic [CNT_W-1:0] per_act,
   input  logic [CNT_W-1:0] per_shadow,
   output logic [CNT_W-1:0] count,
   output logic             dir,
   output logic             evt
);
   logic [CNT_W-1:0] nxt_cnt;
   logic [CNT_W:0]   inc;
   logic             nxt_dir, turn;

   assign inc = {1'b0, count} + 1'b1;

   always_comb begin
      nxt_cnt = count;
      nxt_dir = dir;
      turn    = 1'b0;
      if (center) begin
         if (!dir) begin
            if (inc >= {1'b0, per_act}) begin
               nxt_cnt = per_act;
               nxt_dir = 1'b1;
               turn    = 1'b1;
            end else begin
               nxt_cnt = inc[CNT_W-1:0];
            end
         end else begin
            if (count <= CNT_W'(1)) begin
               nxt_cnt = '0;
               nxt_dir = 1'b0;
               turn    = 1'b1;
            end else begin
               nxt_cnt = count - 1'b1;
            end
         end
      end else if (!dir) begin
         if (count >= per_act) begin
            nxt_cnt = '0;
            turn    = 1'b1;
         end else begin
            nxt_cnt = inc[CNT_W-1:0];
         end
      end else begin
         if (count == '0) begin
            nxt_cnt = per_act;
            turn    = 1'b1;
         end else begin
            nxt_cnt = count - 1'b1;
         end
      end
   end

   assign evt = tick && turn && !sw_upd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         dir   <= 1'b0;
      end else begin
         if (sw_upd)
            count <= dir ? per_shadow : '0;
         else if (tick) begin
            count <= nxt_cnt;
            dir   <= nxt_dir;
         end
         if (dir_we)
            dir <= dir_wval;
      end
   end
endmodule

// File: rtl/updn_timer.sv
module updn_timer
   import updn_timer_pkg::*;
#(
   parameter int  CNT_W    = 16,
   parameter int  DIV_W    = 16,
   parameter bit  PRESC_EN = 1'b1,
   localparam int BUS_W    = (CNT_W > DIV_W) ? CNT_W : DIV_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic [CNT_W-1:0]  count_o,
   output logic              dir_o,
   output logic              flag_o
);
   generate
      if (CNT_W < 2)       begin : g_bad_cnt $error("CNT_W must be at least 2"); end
      if (DIV_W < 1)       begin : g_bad_div $error("DIV_W must be at least 1"); end
      if (BUS_W < CTRL_W)  begin : g_bad_bus $error("bus too narrow for control"); end
   endgenerate

   ctrl_t            ctrl;
   logic             sw_upd, dir_we, dir_wval, tick, hw_evt;
   logic [CNT_W-1:0] per_shadow, per_act;
   logic [DIV_W-1:0] div_shadow;

   updn_timer_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .BUS_W(BUS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_evt(hw_evt),
      .dir_stat(dir_o), .count(count_o), .ctrl(ctrl), .sw_upd(sw_upd),
      .dir_we(dir_we), .dir_wval(dir_wval), .per_shadow(per_shadow),
      .per_act(per_act), .div_shadow(div_shadow), .flag(flag_o)
   );

   updn_timer_presc #(.DIV_W(DIV_W), .PRESC_EN(PRESC_EN)) u_presc (
      .clk(clk), .rst_n(rst_n), .en(ctrl.en), .update(hw_evt || sw_upd),
      .div_shadow(div_shadow), .tick(tick)
   );

   updn_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sw_upd(sw_upd),
      .center(ctrl.mode != 2'b00), .dir_we(dir_we), .dir_wval(dir_wval),
      .per_act(per_act), .per_shadow(per_shadow), .count(count_o),
      .dir(dir_o), .evt(hw_evt)
   );
endmodule

// File: rtl/updn_timer_chk.sv
module updn_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [1:0]       mode,
   input logic             tick,
   input logic             evt,
   input logic             sw_upd,
   input logic             stat_clr,
   input logic             dir,
   input logic             flag,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] per_act
);
   assert_evt_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag);

   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !stat_clr) |=> flag);

   assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !sw_upd) |=> $stable(count));

   assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !sw_upd && !evt && mode == 2'b00 && !dir)
      |=> count == CNT_W'($past(count) + 1'b1));

   assert_down_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && mode == 2'b00 && dir) |=> count == $past(per_act));

   assert_center_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && mode != 2'b00 && !dir) |=> (dir && count == $past(per_act)));

   assert_dir_readonly_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b00 && !tick) |=> $stable(dir));

   assert_swupd_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_upd && !flag) |=> !flag);
endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(ctrl.en), .mode(ctrl.mode), .tick(tick),
   .evt(hw_evt), .sw_upd(sw_upd),
   .stat_clr(reg_wr && (reg_addr == 3'd1) && !reg_wdata[0]),
   .dir(dir_o), .flag(flag_o), .count(count_o), .per_act(per_act)
);

// File: tb/updn_timer_tb.sv
module updn_timer_tb;
   localparam int CLK_P = 10;
   localparam int S_CNT = 0, S_FLG = 1, S_DIR = 2, S_RD = 3;

   typedef struct {
      string tag;
      int    sel;
      int    exp;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr;
   logic [2:0]  reg_addr;
   logic [15:0] reg_wdata;
   logic [15:0] reg_rdata;
   logic [15:0] count_o;
   logic        dir_o, flag_o;

   item_t sb_q[$];
   int    n_chk = 0;
   int    n_err = 0;
   bit    done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   updn_timer u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_o(count_o),
      .dir_o(dir_o), .flag_o(flag_o)
   );

   // monitor: compares queued expectations one time unit after they are pushed
   initial begin
      forever begin
         wait (sb_q.size() != 0);
         #1;
         while (sb_q.size() != 0) begin
            item_t it;
            int    act;
            it = sb_q.pop_front();
            case (it.sel)
               S_CNT:   act = int'(count_o);
               S_FLG:   act = int'(flag_o);
               S_DIR:   act = int'(dir_o);
               default: act = int'(reg_rdata);
            endcase
            n_chk++;
            if (act != it.exp) begin
               n_err++;
               $display("FAIL %s: got %0h expected %0h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic expect_o(input string tag, input int sel, input int exp);
      item_t it;
      it.tag = tag; it.sel = sel; it.exp = exp;
      sb_q.push_back(it);
   endtask

   task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
      reg_addr = a;
      expect_o(tag, S_RD, exp);
      #2;
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic tickn(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 5000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_o("R1 count after reset", S_CNT, 0);
      expect_o("R1 flag after reset", S_FLG, 0);
      expect_o("R1 dir after reset", S_DIR, 0);
      rd_chk("R1 control after reset", 3'd0, 0);
      rd_chk("R1 period after reset", 3'd3, 16'hFFFF);
      @(negedge clk);
      rd_chk("R1 divider after reset", 3'd4, 0);
      @(negedge clk);

      // up counting, unbuffered period
      wr(3'd3, 16'd5);
      wr(3'd0, 16'h0001);
      expect_o("R2 count at enable", S_CNT, 0);
      tickn(5);
      expect_o("R2 count at top", S_CNT, 5);
      expect_o("R9 flag before event", S_FLG, 0);
      tickn(1);
      expect_o("R7 wrap at period written unbuffered", S_CNT, 0);
      expect_o("R9 flag set by overflow", S_FLG, 1);
      tickn(1);
      expect_o("R2 count after wrap", S_CNT, 1);

      // disable holds
      wr(3'd0, 16'h0000);
      expect_o("R11 count at disable", S_CNT, 2);
      tickn(3);
      expect_o("R11 count held while disabled", S_CNT, 2);

      // flag clear semantics
      wr(3'd1, 16'h0001);
      expect_o("R9 writing 1 leaves flag", S_FLG, 1);
      wr(3'd1, 16'h0000);
      expect_o("R9 writing 0 clears flag", S_FLG, 0);

      // down counting
      wr(3'd0, 16'h0005);
      expect_o("R5 dir written in edge mode", S_DIR, 1);
      expect_o("R3 count at enable", S_CNT, 2);
      tickn(2);
      expect_o("R3 count reaches zero", S_CNT, 0);
      expect_o("R3 no flag at zero", S_FLG, 0);
      tickn(1);
      expect_o("R3 reload period", S_CNT, 5);
      expect_o("R3 flag on underflow", S_FLG, 1);
      tickn(1);
      expect_o("R3 count after reload", S_CNT, 4);
      wr(3'd0, 16'h0004);
      expect_o("R11 count at disable", S_CNT, 3);

      // software update request
      wr(3'd1, 16'h0000);
      wr(3'd3, 16'd9);
      wr(3'd0, 16'h0024);
      expect_o("R10 reload to period when down", S_CNT, 9);
      expect_o("R10 update sets no flag", S_FLG, 0);
      rd_chk("R10 update bit reads 0", 3'd0, 16'h0004);
      @(negedge clk);
      wr(3'd0, 16'h0000);
      wr(3'd0, 16'h0020);
      expect_o("R10 reload to 0 when up", S_CNT, 0);
      expect_o("R10 flag still clear", S_FLG, 0);

      // prescaler staging
      wr(3'd4, 16'd3);
      rd_chk("R8 divider readback", 3'd4, 3);
      @(negedge clk);
      wr(3'd0, 16'h0001);
      expect_o("R8 count at enable", S_CNT, 0);
      tickn(2);
      expect_o("R8 staged divider not yet live", S_CNT, 2);
      wr(3'd0, 16'h0021);
      expect_o("R10 update restarts count", S_CNT, 0);
      tickn(3);
      expect_o("R8 no tick before fourth clock", S_CNT, 0);
      tickn(1);
      expect_o("R8 tick on fourth clock", S_CNT, 1);
      tickn(4);
      expect_o("R8 next tick four clocks later", S_CNT, 2);

      // buffered period
      wr(3'd0, 16'h0000);
      wr(3'd4, 16'd0);
      wr(3'd0, 16'h0020);
      wr(3'd3, 16'd4);
      wr(3'd0, 16'h0003);
      expect_o("R6 count at enable", S_CNT, 0);
      tickn(2);
      wr(3'd3, 16'd7);
      expect_o("R6 count during staged write", S_CNT, 3);
      rd_chk("R6 shadow readback", 3'd3, 7);
      @(negedge clk);
      expect_o("R6 still counting to old period", S_CNT, 4);
      tickn(1);
      expect_o("R6 wraps at old period", S_CNT, 0);
      expect_o("R6 flag on old-period wrap", S_FLG, 1);
      tickn(7);
      expect_o("R6 new period live", S_CNT, 7);
      tickn(1);
      expect_o("R6 wraps at new period", S_CNT, 0);

      // set and clear in the same cycle
      wr(3'd1, 16'h0000);
      expect_o("R9 clear away from event", S_FLG, 0);
      tickn(6);
      expect_o("R9 count before wrap", S_CNT, 7);
      wr(3'd1, 16'h0000);
      expect_o("R9 wrap with clear", S_CNT, 0);
      expect_o("R9 set wins over clear", S_FLG, 1);
      wr(3'd1, 16'h0000);
      expect_o("R9 later clear works", S_FLG, 0);

      // centre-aligned
      wr(3'd0, 16'h0002);
      wr(3'd3, 16'd3);
      wr(3'd0, 16'h002A);
      expect_o("R10 reload before centre mode", S_CNT, 0);
      wr(3'd0, 16'h000B);
      tickn(2);
      expect_o("R4 rising count", S_CNT, 2);
      expect_o("R4 dir up", S_DIR, 0);
      expect_o("R4 no flag yet", S_FLG, 0);
      tickn(1);
      expect_o("R4 peak at period", S_CNT, 3);
      expect_o("R4 dir turns down", S_DIR, 1);
      expect_o("R4 flag at peak", S_FLG, 1);
      wr(3'd1, 16'h0000);
      expect_o("R4 falling count", S_CNT, 2);
      expect_o("R4 flag cleared", S_FLG, 0);
      wr(3'd0, 16'h000B);
      expect_o("R5 dir write ignored in centre mode", S_DIR, 1);
      expect_o("R5 count kept falling", S_CNT, 1);
      rd_chk("R5 control shows down", 3'd0, 16'h000F);
      @(negedge clk);
      expect_o("R4 valley at zero", S_CNT, 0);
      expect_o("R4 dir turns up", S_DIR, 0);
      expect_o("R4 flag at valley", S_FLG, 1);
      tickn(1);
      expect_o("R4 rising again", S_CNT, 1);

      @(negedge clk);
      #3;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule